// File: doc/BRIEF.md
# Receive Frame Error Statistics Counters

This block watches the end of every received Ethernet frame and sorts it into one of three kinds. The kinds are a frame that ended on a partial octet (residual bits), a frame longer than a programmable maximum, and a frame that needs no counting. It keeps two saturating 32-bit counters, one for each error kind, so that software can sample link health. A frame is counted in no more than one counter. Residual-bit frames take priority, so an oversized frame with a partial final octet adds only to the residual counter.

Both counters sit behind a small register port. A read strobe returns the addressed counter one cycle later, together with a one-cycle valid pulse, and changes nothing. A write strobe to a counter's address clears that counter. The port carries no write data, because the value written has no effect.

The read side is a two-state machine. The states are `RD_IDLE` (no response pending) and `RD_RESP` (read data valid). The transitions are: idle→resp on a read strobe, resp→resp on another read strobe, and resp→idle when no strobe arrives. Each frame is sorted as `FR_NONE`, `FR_LONG` or `FR_RESID`.

Top module: `rx_err_stats`

## Requirements
- R1: After reset both counters read zero and `reg_rvalid` is low.
- R2: A frame strobe with `resid_bits` low and `frame_len` strictly greater than `max_len` adds one to the too-long counter on that clock edge.
- R3: A frame with `frame_len` equal to or less than `max_len` and `resid_bits` low changes neither counter.
- R4: A frame strobe with `resid_bits` high adds one to the residual counter and never to the too-long counter, whatever its length.
- R5: Each frame strobe changes at most one counter, and without a strobe neither counter changes except by a clear.
- R6: A counter at all ones stays at all ones on further qualifying frames.
- R7: A write strobe clears the addressed counter to zero. If an increment of that counter arrives in the same cycle, the write wins.
- R8: A write to one counter leaves the other counter unchanged.
- R9: A read strobe gives `reg_rvalid` high on the next cycle, with `reg_rdata` equal to the counter value as it stood at the strobe edge. Reads never change a counter.
- R10: Address 0 selects the too-long counter and address 1 selects the residual counter. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_strobe | input | 1 | One-cycle end-of-frame marker |
| frame_len | input | LEN_W (16) | Length of the ending frame in bytes |
| resid_bits | input | 1 | Ending frame had a partial final octet |
| max_len | input | LEN_W (16) | Programmed maximum frame length |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (clears the addressed counter) |
| reg_addr | input | ADDR_W (2) | Register address |
| reg_rdata | output | CNT_W (32) | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
A classification fault, such as a wrong comparison edge or an inverted priority, puts a count in the wrong counter. It becomes visible at the next read of either counter, two cycles after the offending frame. Saturation and clear-priority faults appear as a wrapped value or a nonzero value on the read that follows the frame. A fault in the read state machine shows as a missing or late valid pulse on the cycle after the strobe. To make saturation reachable, the bench runs a second copy of the block with 4-bit counters beside the 32-bit one, feeds both the same stimulus, and checks every read of both against an arithmetic model.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_LONG  = 2'd1,
        FR_RESID = 2'd2
    } frame_kind_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    localparam int ADDR_TOO_LONG = 0;
    localparam int ADDR_RESID    = 1;
endpackage

// File: rtl/rx_frame_classify.sv
module rx_frame_classify
    import rx_err_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_strobe,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             resid_bits,
    input  logic [LEN_W-1:0] max_len,
    output logic             inc_long,
    output logic             inc_resid
);
    frame_kind_e kind;

    // Residual bits outrank length.
    always_comb begin
        if (resid_bits)
            kind = FR_RESID;
        else if (frame_len > max_len)
            kind = FR_LONG;
        else
            kind = FR_NONE;
    end

    always_comb begin
        inc_long  = 1'b0;
        inc_resid = 1'b0;
        unique case (kind)
            FR_LONG:  inc_long  = eof_strobe;
            FR_RESID: inc_resid = eof_strobe;
            default:  ;
        endcase
    end

    p_single_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_long, inc_resid}));
    p_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_strobe |-> !inc_long && !inc_resid);
    p_resid_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resid_bits |-> !inc_long);
endmodule

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + CNT_W'(1);
    end

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rx_reg_port.sv
module rx_reg_port
    import rx_err_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt_long,
    input  logic [CNT_W-1:0]  cnt_resid,
    output logic [CNT_W-1:0]  rdata,
    output logic              rvalid
);
    rd_state_e state, state_nx;
    logic [CNT_W-1:0] sel;

    always_comb begin
        unique case (state)
            RD_IDLE: state_nx = rd ? RD_RESP : RD_IDLE;
            RD_RESP: state_nx = rd ? RD_RESP : RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        if (addr == ADDR_W'(ADDR_TOO_LONG))
            sel = cnt_long;
        else if (addr == ADDR_W'(ADDR_RESID))
            sel = cnt_resid;
        else
            sel = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end

    assign rvalid = (state == RD_RESP);

    p_read_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    p_valid_only_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
    import rx_err_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eof_strobe,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              resid_bits,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              reg_rvalid
);
    logic inc_long, inc_resid;
    logic clr_long, clr_resid;
    logic [CNT_W-1:0] cnt_long, cnt_resid;

    assign clr_long  = reg_wr && (reg_addr == ADDR_W'(ADDR_TOO_LONG));
    assign clr_resid = reg_wr && (reg_addr == ADDR_W'(ADDR_RESID));

    rx_frame_classify #(.LEN_W(LEN_W)) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .eof_strobe (eof_strobe),
        .frame_len  (frame_len),
        .resid_bits (resid_bits),
        .max_len    (max_len),
        .inc_long   (inc_long),
        .inc_resid  (inc_resid)
    );

    rx_sat_counter #(.CNT_W(CNT_W)) u_cnt_long (
        .clk (clk), .rst_n (rst_n), .inc (inc_long), .clr (clr_long), .cnt (cnt_long)
    );

    rx_sat_counter #(.CNT_W(CNT_W)) u_cnt_resid (
        .clk (clk), .rst_n (rst_n), .inc (inc_resid), .clr (clr_resid), .cnt (cnt_resid)
    );

    rx_reg_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .cnt_long  (cnt_long),
        .cnt_resid (cnt_resid),
        .rdata     (reg_rdata),
        .rvalid    (reg_rvalid)
    );

    p_other_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_long && !inc_resid) |=> $stable(cnt_resid));
    p_read_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !eof_strobe) |=> $stable(cnt_long) && $stable(cnt_resid));
endmodule

// File: tb/rx_err_stats_tb.sv
module rx_err_stats_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eof_strobe = 1'b0;
    logic [15:0] frame_len = '0;
    logic resid_bits = 1'b0;
    logic [15:0] max_len = 16'd20;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] rdata;
    logic rvalid;
    logic [3:0] rdata_s;
    logic rvalid_s;

    int total = 0, bad = 0;
    longint exp_long = 0, exp_res = 0;
    int exp_long_s = 0, exp_res_s = 0;

    always #2 clk = ~clk;

    rx_err_stats u_dut (
        .clk(clk), .rst_n(rst_n), .eof_strobe(eof_strobe), .frame_len(frame_len),
        .resid_bits(resid_bits), .max_len(max_len), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_rdata(rdata), .reg_rvalid(rvalid)
    );

    rx_err_stats #(.CNT_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .eof_strobe(eof_strobe), .frame_len(frame_len),
        .resid_bits(resid_bits), .max_len(max_len), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_rdata(rdata_s), .reg_rvalid(rvalid_s)
    );

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(int len, bit res, bit clr_long);
        @(negedge clk);
        eof_strobe = 1'b1; frame_len = 16'(len); resid_bits = res;
        reg_wr = clr_long; reg_addr = 2'd0;
        @(negedge clk);
        eof_strobe = 1'b0; reg_wr = 1'b0;
        if (clr_long) begin
            exp_long = 0; exp_long_s = 0;
        end else if (!res && len > int'(max_len)) begin
            exp_long++; if (exp_long_s < 15) exp_long_s++;
        end
        if (res) begin
            exp_res++; if (exp_res_s < 15) exp_res_s++;
        end
    endtask

    task automatic clear(int addr);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(addr);
        @(negedge clk);
        reg_wr = 1'b0;
        if (addr == 0) begin exp_long = 0; exp_long_s = 0; end
        if (addr == 1) begin exp_res = 0; exp_res_s = 0; end
    endtask

    task automatic rd(int addr, string req, longint exp, int exp_s);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'(addr);
        @(negedge clk);
        reg_rd = 1'b0;
        check({req, " valid"}, longint'(rvalid), 1);
        check(req, longint'(rdata), exp);
        check({req, " sat"}, longint'(rdata_s), longint'(exp_s));
    endtask

    task automatic both(string req);
        rd(0, {req, " long"}, exp_long, exp_long_s);
        rd(1, {req, " resid"}, exp_res, exp_res_s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rvalid", longint'(rvalid), 0);
        both("R1");
        // R2 R3 R4 R5: sweep lengths and residual flag around the limit
        for (int m = 0; m < 3; m++) begin
            max_len = (m == 0) ? 16'd20 : (m == 1) ? 16'd0 : 16'hFFFF;
            for (int len = 0; len < 42; len++) begin
                for (int r = 0; r < 2; r++) begin
                    frame(len, r[0], 1'b0);
                    both("R2 R3 R4 R5");
                end
            end
        end
        // R3: equal length at the top of the range
        max_len = 16'hFFFF;
        frame(65535, 1'b0, 1'b0);
        both("R3 equal");
        // R4: residual frame far above limit
        max_len = 16'd10;
        frame(65535, 1'b1, 1'b0);
        both("R4 priority");
        // R9: repeated reads do not change counters
        both("R9 reread");
        both("R9 reread2");
        // R10: unmapped addresses read zero
        rd(2, "R10 addr2", 0, 0);
        rd(3, "R10 addr3", 0, 0);
        // R8: clear too-long only
        clear(0);
        both("R8 clear long");
        // R7: write wins over a same-cycle increment
        frame(50, 1'b0, 1'b0);
        frame(50, 1'b0, 1'b1);
        both("R7 write wins");
        clear(1);
        both("R8 clear resid");
        // R6: saturation visible on the 4-bit copy
        for (int i = 0; i < 20; i++) begin
            frame(100, 1'b0, 1'b0);
            frame(5, 1'b1, 1'b0);
            both("R6 saturate");
        end
        clear(0);
        both("R7 clear from max");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule